// File: doc/BRIEF.md
# DSSS Transmit Preamble and Header Sequencer

This block produces the framing that opens every burst of a direct-sequence spread-spectrum transmitter. When transmit enable rises it sends a short amplifier ramp, then a synchronisation run and a start-of-frame delimiter, then the header fields and their check word. It emits one bit per clock, together with a phase code and a valid flag, so that a downstream scrambler and spreader can follow it. A 2-bit rate code goes with the stream so the modulator can pick its constellation and chip sequence.

Software loads the preamble length, mode, rate, service flags and the 16-bit length field through a small address/data/write-enable port while the transmitter is idle. Writes made while transmit enable is high are dropped. Two test patterns can replace the whole burst for carrier measurements. After the last header bit the block gives a one-cycle done pulse. It then waits in a data phase until transmit enable falls, and hands the payload over to other logic.

Register map: address 0 holds the long-mode sync count. Address 1 is control: bit 0 selects short mode, bits 2:1 hold the rate, bit 3 enables test, and bit 4 picks the constant-ones test. Address 2 holds the service flags. Address 3 holds the length low byte and address 4 the length high byte. Addresses 5 to 7 have no effect.

Top module: `dsss_tx_framer`

## Requirements
- R1: After reset, valid_o, done_o, bit_o, phase_o and rate_o are 0. The registers read as sync count 0x80, long mode, rate 0, service 0 and length 0, so a burst sent with no writes carries 130 symbols of ramp plus sync before its delimiter.
- R2: A burst starts with exactly 2 ramp bits, phase_o = 00, valid_o = 1. The ramp bits are 1 in long mode and 0 in short mode. The first ramp bit appears in the cycle after the clock edge that samples tx_en_i high.
- R3: In long mode, ramp is followed by N one bits, where N is the value at address 0 (0 to 255; 0 means no sync bits). The delimiter 0xF3A0 follows, sent LSB first. All of these carry phase_o = 01.
- R4: In short mode, ramp is followed by exactly 56 zero bits, whatever address 0 holds. The delimiter 0x05CF follows, sent LSB first. All of these carry phase_o = 01.
- R5: The signal byte depends on the rate code: 0 gives 0x0A, 1 gives 0x14, 2 gives 0x37 and 3 gives 0x6E. rate_o always shows the stored rate code.
- R6: The service byte sent carries written bit 7 at bit 7 and written bit 2 at bit 2. Every other service bit is sent as 0, whatever was written.
- R7: The header follows the delimiter with phase_o = 10. It sends signal, then service, then length low byte, then length high byte, each LSB first.
- R8: After the 32 header bits come 16 check bits with phase_o = 10. The check is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, shifted over the 32 header bits in sending order. It is sent inverted, starting with bit 15.
- R9: In the cycle after the last check bit, done_o is 1 for exactly one cycle. From then until tx_en_i falls, phase_o = 11, valid_o = 0 and bit_o = 0.
- R10: Register writes while tx_en_i is high have no effect on rate_o or on any later burst.
- R11: With the test enable bit set, a burst is replaced by a test stream with phase_o = 11 and valid_o = 1. With the constant-ones bit clear the stream alternates 1,0,1,0... starting with 1. With it set the stream is all ones. done_o stays 0.
- R12: When tx_en_i is low at a clock edge, the next cycle shows valid_o = 0, done_o = 0 and phase_o = 00. A new burst then starts from the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (3) | Register address |
| wr_data_i | input | 8 | Register write data |
| bit_o | output | 1 | Serial framing bit |
| valid_o | output | 1 | bit_o carries framing or test data |
| phase_o | output | 2 | 00 ramp, 01 preamble, 10 header, 11 data/test |
| rate_o | output | 2 | Rate code for the modulator |
| done_o | output | 1 | One-cycle pulse after the last header bit |

## Verification
The hardest case to reach from the ports is a write that arrives while a burst is in flight and must leave no trace. Its effect can only show up in a later burst, so the check must span the gap between two bursts. The stimulus holds transmit enable high past the done pulse and rewrites every register during the data phase. It then drops enable without further writes, sends a second burst, and expects the old configuration bit for bit. The sweep covers all rate codes, service flag pairs and both preamble modes, writes ones into the masked service bits, and pushes the sync count to its ends of 0, 1 and 255.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAMP, ST_SYNC, ST_SFD, ST_HDR, ST_CRC, ST_TAIL, ST_TEST
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_RAMP = 2'b00,
    PH_PRE  = 2'b01,
    PH_HDR  = 2'b10,
    PH_DATA = 2'b11
  } phase_e;

  typedef struct packed {
    logic [7:0]  pre_len;
    logic        short_pre;
    logic [1:0]  rate;
    logic        test_en;
    logic        test_cw;
    logic        svc_ext;
    logic        svc_lock;
    logic [15:0] length;
  } tx_cfg_t;

  // rate in units of 100 kbit/s
  function automatic logic [7:0] signal_code(input logic [1:0] r);
    case (r)
      2'd0:    return 8'h0A;
      2'd1:    return 8'h14;
      2'd2:    return 8'h37;
      default: return 8'h6E;
    endcase
  endfunction

endpackage

// File: rtl/dsss_tx_regs.sv
module dsss_tx_regs
  import dsss_tx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output tx_cfg_t           cfg_o
);

  localparam int A_PRE  = 0;
  localparam int A_CTRL = 1;
  localparam int A_SVC  = 2;
  localparam int A_LEN  = 3;
  localparam int LEN_BYTES = 2;

  logic       wr_ok;
  logic [7:0] pre_q;
  logic [4:0] ctrl_q;
  logic       ext_q, lock_q;

  assign wr_ok = wr_en_i & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= 8'h80;
      ctrl_q <= '0;
      ext_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_ok) begin
      if (wr_addr_i == ADDR_W'(A_PRE))  pre_q  <= wr_data_i;
      if (wr_addr_i == ADDR_W'(A_CTRL)) ctrl_q <= wr_data_i[4:0];
      if (wr_addr_i == ADDR_W'(A_SVC)) begin
        ext_q  <= wr_data_i[7];
        lock_q <= wr_data_i[2];
      end
    end
  end

  for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (wr_ok && wr_addr_i == ADDR_W'(A_LEN + g)) byte_q <= wr_data_i;
    end
  end

  assign cfg_o.pre_len   = pre_q;
  assign cfg_o.short_pre = ctrl_q[0];
  assign cfg_o.rate      = ctrl_q[2:1];
  assign cfg_o.test_en   = ctrl_q[3];
  assign cfg_o.test_cw   = ctrl_q[4];
  assign cfg_o.svc_ext   = ext_q;
  assign cfg_o.svc_lock  = lock_q;
  assign cfg_o.length    = {g_len[1].byte_q, g_len[0].byte_q};

endmodule

// File: rtl/dsss_tx_crc.sv
module dsss_tx_crc #(
  parameter int          W    = 16,
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);

  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = crc_q[W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT[W-1:0];
    else if (clr_i)  crc_q <= INIT[W-1:0];
    else if (en_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/dsss_tx_seq.sv
module dsss_tx_seq
  import dsss_tx_pkg::*;
#(
  parameter int          RAMP_LEN   = 2,
  parameter int          SHORT_SYNC = 56,
  parameter logic [15:0] LONG_SFD   = 16'hF3A0,
  parameter logic [15:0] SHORT_SFD  = 16'h05CF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  tx_cfg_t     cfg_i,
  input  logic [15:0] crc_i,
  output logic        crc_clr_o,
  output logic        crc_en_o,
  output logic        hdr_bit_o,
  output logic        bit_o,
  output logic        valid_o,
  output logic [1:0]  phase_o,
  output logic        done_o
);

  localparam int SFD_BITS = 16;
  localparam int HDR_BITS = 32;
  localparam int CRC_BITS = 16;
  localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(RAMP_LEN - 1);
  localparam logic [CNT_W-1:0] SFD_LAST  = CNT_W'(SFD_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_BITS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;
  logic [CNT_W-1:0] sync_len;
  logic [15:0]      sfd;
  logic [7:0]       svc_byte;
  logic [31:0]      hdr_word;
  logic             sync_val;

  assign sync_len = cfg_i.short_pre ? CNT_W'(SHORT_SYNC) : cfg_i.pre_len;
  assign sfd      = cfg_i.short_pre ? SHORT_SFD : LONG_SFD;
  assign sync_val = ~cfg_i.short_pre;
  assign svc_byte = {cfg_i.svc_ext, 4'b0000, cfg_i.svc_lock, 2'b00};
  assign hdr_word = {cfg_i.length, svc_byte, signal_code(cfg_i.rate)};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    if (!tx_en_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d   = '0;
          state_d = cfg_i.test_en ? ST_TEST : ST_RAMP;
        end
        ST_RAMP: if (cnt_q == RAMP_LAST) begin
          cnt_d   = '0;
          state_d = (sync_len == '0) ? ST_SFD : ST_SYNC;
        end
        ST_SYNC: if (cnt_q == sync_len - CNT_W'(1)) begin
          cnt_d   = '0;
          state_d = ST_SFD;
        end
        ST_SFD: if (cnt_q == SFD_LAST) begin
          cnt_d   = '0;
          state_d = ST_HDR;
        end
        ST_HDR: if (cnt_q == HDR_LAST) begin
          cnt_d   = '0;
          state_d = ST_CRC;
        end
        ST_CRC: if (cnt_q == CRC_LAST) begin
          cnt_d   = '0;
          state_d = ST_TAIL;
        end
        ST_TAIL: cnt_d = cnt_q;
        ST_TEST: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= tx_en_i && state_q == ST_CRC && cnt_q == CRC_LAST;
    end
  end

  always_comb begin
    bit_o   = 1'b0;
    valid_o = 1'b1;
    phase_o = PH_RAMP;
    unique case (state_q)
      ST_IDLE: valid_o = 1'b0;
      ST_RAMP: bit_o = sync_val;
      ST_SYNC: begin
        phase_o = PH_PRE;
        bit_o   = sync_val;
      end
      ST_SFD: begin
        phase_o = PH_PRE;
        bit_o   = sfd[cnt_q[3:0]];
      end
      ST_HDR: begin
        phase_o = PH_HDR;
        bit_o   = hdr_word[cnt_q[4:0]];
      end
      ST_CRC: begin
        phase_o = PH_HDR;
        bit_o   = ~crc_i[4'd15 - cnt_q[3:0]];
      end
      ST_TAIL: begin
        phase_o = PH_DATA;
        valid_o = 1'b0;
      end
      ST_TEST: begin
        phase_o = PH_DATA;
        bit_o   = cfg_i.test_cw | ~cnt_q[0];
      end
      default: valid_o = 1'b0;
    endcase
  end

  assign crc_clr_o = (state_q == ST_IDLE);
  assign crc_en_o  = (state_q == ST_HDR);
  assign hdr_bit_o = hdr_word[cnt_q[4:0]];
  assign done_o    = done_q;

endmodule

// File: rtl/dsss_tx_framer.sv
module dsss_tx_framer
  import dsss_tx_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int RAMP_LEN   = 2,
  parameter int SHORT_SYNC = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              bit_o,
  output logic              valid_o,
  output logic [1:0]        phase_o,
  output logic [1:0]        rate_o,
  output logic              done_o
);

  tx_cfg_t     cfg;
  logic [15:0] crc;
  logic        crc_clr, crc_en, hdr_bit;

  dsss_tx_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (tx_en_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg)
  );

  dsss_tx_crc #(.W(16)) i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .bit_i (hdr_bit),
    .crc_o (crc)
  );

  dsss_tx_seq #(
    .RAMP_LEN  (RAMP_LEN),
    .SHORT_SYNC(SHORT_SYNC)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en_i),
    .cfg_i    (cfg),
    .crc_i    (crc),
    .crc_clr_o(crc_clr),
    .crc_en_o (crc_en),
    .hdr_bit_o(hdr_bit),
    .bit_o    (bit_o),
    .valid_o  (valid_o),
    .phase_o  (phase_o),
    .done_o   (done_o)
  );

  assign rate_o = cfg.rate;

endmodule

// File: rtl/dsss_tx_framer_chk.sv
module dsss_tx_framer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       valid_o,
  input logic [1:0] phase_o,
  input logic [1:0] rate_o,
  input logic       done_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!valid_o && !done_o && phase_o == 2'b00)); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (phase_o == 2'b11 && !valid_o)); // R9

  AST_RATE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> $stable(rate_o)); // R10

  AST_START_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (phase_o == 2'b00 || phase_o == 2'b11)); // R2

  AST_NO_PRE_AFTER_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && phase_o == 2'b10) |=> !(valid_o && phase_o == 2'b01)); // R7

endmodule

bind dsss_tx_framer dsss_tx_framer_chk i_chk (.*);

// File: tb/test_dsss_tx_framer.sv
module test_dsss_tx_framer;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       bit_o, valid_o, done_o;
  logic [1:0] phase_o, rate_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0]  s_pre = 8'h80;
  logic        s_short = 0;
  logic [1:0]  s_rate = 0;
  logic        s_ext = 0, s_lock = 0;
  logic [15:0] s_len = 0;
  string       ctx = "";

  logic       exp_bit[MAXB];
  logic [1:0] exp_ph[MAXB];
  string      exp_tag[MAXB];
  int         exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsss_tx_framer i_dsss_tx_framer (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .bit_o(bit_o), .valid_o(valid_o),
    .phase_o(phase_o), .rate_o(rate_o), .done_o(done_o)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s %s: actual %0h expected %0h", tag, ctx, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_cfg();
    wr(3'd0, s_pre);
    wr(3'd1, {5'b0, s_rate, s_short});
    wr(3'd2, {s_ext, 4'b1111, s_lock, 2'b11}); // ones in masked bits, R6
    wr(3'd3, s_len[7:0]);
    wr(3'd4, s_len[15:8]);
  endtask

  function automatic logic [15:0] crc_ref(input logic [31:0] w);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb;
      fb = c[15] ^ w[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] sig_ref(input logic [1:0] r);
    case (r)
      2'd0: return 8'd10;
      2'd1: return 8'd20;
      2'd2: return 8'd55;
      default: return 8'd110;
    endcase
  endfunction

  task automatic push(input logic b, input logic [1:0] p, input string t);
    exp_bit[exp_n] = b; exp_ph[exp_n] = p; exp_tag[exp_n] = t; exp_n++;
  endtask

  task automatic build();
    logic [15:0] sfd, c;
    logic [31:0] w;
    int nsync;
    exp_n = 0;
    for (int i = 0; i < 2; i++) push(~s_short, 2'b00, "R2");
    nsync = s_short ? 56 : int'(s_pre);
    sfd = s_short ? 16'h05CF : 16'hF3A0;
    for (int i = 0; i < nsync; i++) push(~s_short, 2'b01, s_short ? "R4" : "R3");
    for (int i = 0; i < 16; i++) push(sfd[i], 2'b01, s_short ? "R4" : "R3");
    w = {s_len, {s_ext, 4'b0, s_lock, 2'b0}, sig_ref(s_rate)};
    for (int i = 0; i < 32; i++) push(w[i], 2'b10, i < 8 ? "R5" : (i < 16 ? "R6" : "R7"));
    c = crc_ref(w);
    for (int i = 0; i < 16; i++) push(~c[15-i], 2'b10, "R8");
  endtask

  // sends a full burst; optional writes during the data phase
  task automatic run_frame(input bit late_writes);
    build();
    @(negedge clk);
    tx_en = 1;
    for (int i = 0; i < exp_n; i++) begin
      @(negedge clk);
      check(exp_tag[i], $sformatf("bit %0d", i), {29'b0, valid_o, bit_o, 1'b0} | {30'b0, exp_ph[i] ^ phase_o},
            {29'b0, 1'b1, exp_bit[i], 1'b0});
    end
    @(negedge clk);
    check("R9", "done pulse", {29'b0, done_o, phase_o}, {29'b0, 1'b1, 2'b11});
    check("R9", "tail valid/bit", {30'b0, valid_o, bit_o}, 32'd0);
    if (late_writes) begin
      wr(3'd1, {5'b0, ~s_rate, ~s_short});
      wr(3'd0, s_pre + 8'd7);
      wr(3'd3, ~s_len[7:0]);
      wr(3'd4, ~s_len[15:8]);
      wr(3'd2, 8'hFF);
      check("R10", "rate during tx", {30'b0, rate_o}, {30'b0, s_rate});
    end
    @(negedge clk);
    check("R9", "tail hold", {28'b0, done_o, valid_o, phase_o}, {28'b0, 2'b00, 2'b11});
    tx_en = 0;
    @(negedge clk);
    check("R12", "idle after drop", {28'b0, done_o, valid_o, phase_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ctx = "reset";
    check("R1", "outputs", {27'b0, bit_o, valid_o, done_o, rate_o}, 32'd0);
    check("R1", "phase", {30'b0, phase_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    ctx = "R1 defaults";
    run_frame(0);

    for (int sh = 0; sh < 2; sh++)
      for (int r = 0; r < 4; r++)
        for (int sv = 0; sv < 4; sv++) begin
          s_short = sh[0]; s_rate = r[1:0]; s_ext = sv[1]; s_lock = sv[0];
          s_pre = 8'h38 + 8'(r);
          s_len = 16'(r * 4099 + sv * 17 + sh * 32769);
          load_cfg();
          ctx = $sformatf("sweep sh%0d r%0d sv%0d", sh, r, sv);
          check("R5", "rate_o", {30'b0, rate_o}, {30'b0, s_rate});
          run_frame(0);
        end

    s_short = 0;
    foreach (s_pre_list[k]) begin
      s_pre = s_pre_list[k];
      load_cfg();
      ctx = $sformatf("R3 sync %0d", s_pre);
      run_frame(0);
    end

    // R4: short mode ignores sync count register
    s_short = 1; s_pre = 8'h05; load_cfg();
    ctx = "R4 short pre5";
    run_frame(0);

    // R10: writes in flight dropped, next burst uses old settings
    s_short = 0; s_pre = 8'h10; s_rate = 2; s_len = 16'hA55A; s_ext = 1; s_lock = 0;
    load_cfg();
    ctx = "R10 first";
    run_frame(1);
    ctx = "R10 second";
    run_frame(0);

    // R12: abort mid preamble, then clean restart
    ctx = "R12 abort";
    @(negedge clk); tx_en = 1;
    repeat (20) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    check("R12", "abort idle", {28'b0, done_o, valid_o, phase_o}, 32'd0);
    run_frame(0);

    // R11: test patterns
    for (int cw = 0; cw < 2; cw++) begin
      ctx = $sformatf("R11 cw%0d", cw);
      wr(3'd1, {3'b0, cw[0], 1'b1, s_rate, s_short});
      @(negedge clk); tx_en = 1;
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        check("R11", $sformatf("test bit %0d", i), {28'b0, done_o, valid_o, bit_o, phase_o == 2'b11},
              {28'b0, 1'b0, 1'b1, (cw == 1) ? 1'b1 : ((i % 2) == 0), 1'b1});
      end
      tx_en = 0;
      @(negedge clk);
      check("R12", "test exit", {30'b0, valid_o, done_o}, 32'd0);
    end
    wr(3'd1, {5'b0, s_rate, s_short});
    ctx = "after test";
    run_frame(0);

    finished = 1;
    report();
  end

  logic [7:0] s_pre_list[3] = '{8'd0, 8'd1, 8'd255};

endmodule